// File: doc/BRIEF.md
# Framed Command Packet Handler

This block sits behind a byte-wide serial receiver and turns an incoming byte stream into decoded commands. A frame opens with a 0xFF byte and carries a command code, four 16-bit setpoints, and a two-byte CRC. The handler checks the CRC and decodes the command. For a valid, recognised command it loads the setpoints into output registers and raises a one-cycle action pulse. Bit timing of the serial line is handled elsewhere. Bytes arrive and leave on valid/ready handshakes.

Each received frame ends in one of three ways. A data-gathering command gets a short acknowledge reply frame. A bad frame or an unknown command gets an error reply frame. A data-transfer command gets no reply at all, only a start pulse for the separate data sender. A setpoint of 0x8000 is flagged as a request for automatic short-circuit current measurement on that channel. Reception is accepted only while an external polling-window input is high. A partial frame is dropped if the line goes quiet for longer than a set number of cycles.

Top module: `cmd_frame_handler`

## Requirements
- R1: While no frame is in progress, any byte other than 0xFF is discarded. A 0xFF byte opens a frame, and a 0xFF byte inside a frame is treated as ordinary data.
- R2: A command frame is 12 bytes: byte 0 is the header 0xFF, byte 1 is the command code, bytes 2..9 are four setpoints (low byte first), and bytes 10 and 11 are the CRC (low byte first). The CRC is CRC-16 with polynomial 0x1021, initial value 0xFFFF, processed MSB first with no reflection and no final XOR, over bytes 0..9. On a CRC mismatch the block sends the error frame, keeps its setpoints, and pulses no action.
- R3: A CRC-valid frame with code 1, 2, 3 or 4 pulses `act_get_status`, `act_get_curves`, `act_send_status` or `act_send_all` respectively. The pulse is high for exactly one cycle, and at most one action pulses at a time.
- R4: A CRC-valid frame with a code of 1 to 4 loads setpoint i (i = 0..3, taken from bytes 2+2i and 3+2i) onto `setpt_o[16*i+15:16*i]`, in the same cycle as the action pulse. No other frame changes `setpt_o`.
- R5: `auto_isc_o[i]` is 1 exactly when the stored setpoint i equals 0x8000.
- R6: After a valid frame with code 1 or 2, the block sends the 4-byte acknowledge frame 0xFF, 0x03, CRC low, CRC high. This CRC is the R2 CRC taken over 0xFF and 0x03.
- R7: A CRC-valid frame with any code outside 1..4 sends the 4-byte error frame 0xFF, 0x04, CRC low, CRC high, and changes no setpoint.
- R8: Valid frames with code 3 or 4 produce no reply bytes.
- R9: If GAP_LIMIT consecutive cycles pass inside a frame with no byte accepted, the frame is abandoned: no pulse, no reply, no setpoint change. A gap of GAP_LIMIT-1 cycles leaves the frame intact.
- R10: While `window_en` is low, accepted bytes are discarded and any partial frame is abandoned.
- R11: While `out_valid` is high and `out_ready` is low, `out_data` holds its value. `in_ready` stays low from the cycle after a frame's last byte until its reply has fully left.
- R12: After reset, `out_valid` and all action pulses are 0, `in_ready` is 1, and all setpoints and auto flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| window_en | input | 1 | High while command reception is permitted |
| in_valid | input | 1 | Received byte present |
| in_data | input | 8 | Received byte |
| in_ready | output | 1 | Handler can take a byte |
| out_valid | output | 1 | Reply byte present |
| out_data | output | 8 | Reply byte |
| out_ready | input | 1 | Downstream takes the reply byte |
| setpt_o | output | 64 | Four stored setpoints, channel i at bits 16*i+15:16*i |
| auto_isc_o | output | 4 | Per-channel automatic-measurement flag |
| act_get_status | output | 1 | Pulse: gather temperature, sun and health data |
| act_get_curves | output | 1 | Pulse: gather current-voltage curves |
| act_send_status | output | 1 | Pulse: start sending status data |
| act_send_all | output | 1 | Pulse: start sending all stored data |

## Verification
Every command code from 0 to 7 is sent in a frame with a correct CRC. This separates the acknowledged codes, the silent transfer codes and the rejected codes by their reply bytes, action pulses and setpoint updates. The setpoints include 0xFFFF and 0x8000 on rotating channels, which exercises header-valued data inside a frame and the auto flag on every channel. Frames with a corrupted CRC, leading junk bytes, idle gaps exactly one cycle below and exactly at the limit, window drops, and a stalled reply output each show one way a frame can be rejected, survive or be held.

// File: rtl/cmdfr_pkg.sv
package cmdfr_pkg;

    localparam int BYTE_W   = 8;
    localparam int SP_W     = 16;
    localparam int NUM_ACT  = 4;

    localparam logic [7:0]  HDR_BYTE  = 8'hFF;
    localparam logic [7:0]  ID_ACK    = 8'h03;
    localparam logic [7:0]  ID_ERR    = 8'h04;
    localparam logic [15:0] AUTO_CODE = 16'h8000;
    localparam logic [15:0] CRC_POLY  = 16'h1021;
    localparam logic [15:0] CRC_INIT  = 16'hFFFF;

    typedef enum logic [1:0] {
        RPL_NONE = 2'd0,
        RPL_ACK  = 2'd1,
        RPL_ERR  = 2'd2
    } reply_kind_e;

    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {b, 8'h00};
        for (int k = 0; k < 8; k++) begin
            r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/cmdfr_rx_parser.sv
module cmdfr_rx_parser
    import cmdfr_pkg::*;
#(
    parameter int NUM_SP    = 4,
    parameter int GAP_LIMIT = 1024
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   window_en,
    input  logic                   byte_fire,
    input  logic [BYTE_W-1:0]      byte_in,
    output logic [NUM_SP*SP_W-1:0] sp_flat,
    output logic [NUM_ACT-1:0]     act_o,
    output logic                   reply_req_o,
    output reply_kind_e            reply_kind_o
);
    localparam int FRAME_LEN  = 2 + 2*NUM_SP + 2;
    localparam int IDX_W      = $clog2(FRAME_LEN);
    localparam int GAP_W      = $clog2(GAP_LIMIT);
    localparam int SLOT_W     = (NUM_SP > 1) ? $clog2(NUM_SP) : 1;
    localparam int CRC_LO_IDX = FRAME_LEN - 2;
    localparam int LAST_IDX   = FRAME_LEN - 1;

    typedef struct packed {
        logic                         in_frame;
        logic [IDX_W-1:0]             idx;
        logic [GAP_W-1:0]             gap;
        logic [15:0]                  crc;
        logic [7:0]                   code;
        logic [7:0]                   crc_lo;
        logic [NUM_SP-1:0][SP_W-1:0]  shadow;
        logic [NUM_SP-1:0][SP_W-1:0]  sp;
        logic [NUM_ACT-1:0]           act;
        logic                         req;
        reply_kind_e                  kind;
    } rx_state_t;

    rx_state_t st_d, st_q;

    logic [IDX_W-1:0]  rel;
    logic [SLOT_W-1:0] slot;
    logic              half;
    logic              crc_ok;
    logic              code_ok;

    always_comb begin
        rel     = st_q.idx - IDX_W'(2);
        slot    = rel[SLOT_W:1];
        half    = rel[0];
        crc_ok  = ({byte_in, st_q.crc_lo} == st_q.crc);
        code_ok = (st_q.code >= 8'd1) && (st_q.code <= 8'(NUM_ACT));

        st_d     = st_q;
        st_d.act = '0;
        st_d.req = 1'b0;

        if (!window_en) begin
            st_d.in_frame = 1'b0;
            st_d.gap      = '0;
        end else if (!st_q.in_frame) begin
            if (byte_fire && byte_in == HDR_BYTE) begin
                st_d.in_frame = 1'b1;
                st_d.idx      = IDX_W'(1);
                st_d.gap      = '0;
                st_d.crc      = crc16_step(CRC_INIT, HDR_BYTE);
            end
        end else if (byte_fire) begin
            st_d.gap = '0;
            st_d.idx = st_q.idx + IDX_W'(1);
            if (st_q.idx < IDX_W'(CRC_LO_IDX)) begin
                st_d.crc = crc16_step(st_q.crc, byte_in);
            end
            if (st_q.idx == IDX_W'(1)) begin
                st_d.code = byte_in;
            end
            if (st_q.idx >= IDX_W'(2) && st_q.idx < IDX_W'(CRC_LO_IDX)) begin
                st_d.shadow[slot][8*half +: 8] = byte_in;
            end
            if (st_q.idx == IDX_W'(CRC_LO_IDX)) begin
                st_d.crc_lo = byte_in;
            end
            if (st_q.idx == IDX_W'(LAST_IDX)) begin
                st_d.in_frame = 1'b0;
                st_d.req      = 1'b1;
                if (crc_ok && code_ok) begin
                    st_d.sp                        = st_q.shadow;
                    st_d.act[st_q.code[1:0] - 2'd1] = 1'b1;
                    if (st_q.code <= 8'd2) begin
                        st_d.kind = RPL_ACK;
                    end else begin
                        st_d.kind = RPL_NONE;
                        st_d.req  = 1'b0;
                    end
                end else begin
                    st_d.kind = RPL_ERR;
                end
            end
        end else if (st_q.gap == GAP_W'(GAP_LIMIT - 1)) begin
            st_d.in_frame = 1'b0;
            st_d.gap      = '0;
        end else begin
            st_d.gap = st_q.gap + GAP_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sp_flat      = st_q.sp;
    assign act_o        = st_q.act;
    assign reply_req_o  = st_q.req;
    assign reply_kind_o = st_q.kind;

    a_r3_act_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act_o));
    a_r3_act_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (act_o != '0) |=> (act_o == '0));
    a_r4_sp_moves_with_act: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sp_flat) |-> (act_o != '0));
    a_r2_no_act_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        (reply_req_o && reply_kind_o == RPL_ERR) |-> (act_o == '0));
    a_r10_window_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        !window_en |=> !st_q.in_frame);
    a_r9_gap_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (window_en && st_q.in_frame && !byte_fire && st_q.gap == GAP_W'(GAP_LIMIT - 1))
        |=> !st_q.in_frame);
endmodule

// File: rtl/cmdfr_reply_tx.sv
module cmdfr_reply_tx
    import cmdfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  reply_kind_e       kind,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              busy
);
    typedef struct packed {
        logic        busy;
        logic [1:0]  pos;
        logic [7:0]  id;
        logic [15:0] crc;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic [7:0] id_pick;

    always_comb begin
        id_pick = (kind == RPL_ACK) ? ID_ACK : ID_ERR;
        st_d    = st_q;
        if (!st_q.busy) begin
            if (req && kind != RPL_NONE) begin
                st_d.busy = 1'b1;
                st_d.pos  = 2'd0;
                st_d.id   = id_pick;
                st_d.crc  = crc16_step(crc16_step(CRC_INIT, HDR_BYTE), id_pick);
            end
        end else if (out_ready) begin
            st_d.pos = st_q.pos + 2'd1;
            if (st_q.pos == 2'd3) begin
                st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (st_q.pos)
            2'd0:    out_data = HDR_BYTE;
            2'd1:    out_data = st_q.id;
            2'd2:    out_data = st_q.crc[7:0];
            default: out_data = st_q.crc[15:8];
        endcase
    end

    assign out_valid = st_q.busy;
    assign busy      = st_q.busy;

    a_r11_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    a_r6_reply_opens_with_header: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_data == HDR_BYTE));
    a_r11_no_req_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req);
endmodule

// File: rtl/cmd_frame_handler.sv
module cmd_frame_handler
    import cmdfr_pkg::*;
#(
    parameter int NUM_SP    = 4,
    parameter int GAP_LIMIT = 1024
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   window_en,
    input  logic                   in_valid,
    input  logic [7:0]             in_data,
    output logic                   in_ready,
    output logic                   out_valid,
    output logic [7:0]             out_data,
    input  logic                   out_ready,
    output logic [NUM_SP*16-1:0]   setpt_o,
    output logic [NUM_SP-1:0]      auto_isc_o,
    output logic                   act_get_status,
    output logic                   act_get_curves,
    output logic                   act_send_status,
    output logic                   act_send_all
);
    logic               byte_fire;
    logic [NUM_ACT-1:0] act;
    logic               reply_req;
    reply_kind_e        reply_kind;
    logic               tx_busy;

    assign in_ready  = !(tx_busy || reply_req);
    assign byte_fire = in_valid && in_ready;

    cmdfr_rx_parser #(
        .NUM_SP    (NUM_SP),
        .GAP_LIMIT (GAP_LIMIT)
    ) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .window_en    (window_en),
        .byte_fire    (byte_fire),
        .byte_in      (in_data),
        .sp_flat      (setpt_o),
        .act_o        (act),
        .reply_req_o  (reply_req),
        .reply_kind_o (reply_kind)
    );

    cmdfr_reply_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (reply_req),
        .kind      (reply_kind),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .busy      (tx_busy)
    );

    for (genvar i = 0; i < NUM_SP; i++) begin : g_auto
        assign auto_isc_o[i] = (setpt_o[16*i +: 16] == AUTO_CODE);
    end

    assign act_get_status  = act[0];
    assign act_get_curves  = act[1];
    assign act_send_status = act[2];
    assign act_send_all    = act[3];

    a_r11_ready_low_during_reply: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
    a_r5_auto_tracks_setpoint: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(auto_isc_o[0]) |-> (act != '0));
endmodule

// File: tb/cmd_frame_handler_test.sv
module cmd_frame_handler_test;
    localparam int GAP = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        window_en = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_ready = 1'b1;
    logic [63:0] setpt_o;
    logic [3:0]  auto_isc_o;
    logic        act_get_status, act_get_curves, act_send_status, act_send_all;

    int checks = 0;
    int errors = 0;
    logic [7:0]  rbuf [0:15];
    int          rn = 0;
    int          pc [0:3];
    logic [15:0] exp_sp [0:3];

    always #2 clk = ~clk;

    cmd_frame_handler #(.NUM_SP(4), .GAP_LIMIT(GAP)) uut (
        .clk(clk), .rst_n(rst_n), .window_en(window_en),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .setpt_o(setpt_o), .auto_isc_o(auto_isc_o),
        .act_get_status(act_get_status), .act_get_curves(act_get_curves),
        .act_send_status(act_send_status), .act_send_all(act_send_all)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && out_ready && rn < 16) begin
                rbuf[rn] = out_data;
                rn = rn + 1;
            end
            if (act_get_status)  pc[0] = pc[0] + 1;
            if (act_get_curves)  pc[1] = pc[1] + 1;
            if (act_send_status) pc[2] = pc[2] + 1;
            if (act_send_all)    pc[3] = pc[3] + 1;
        end
    end

    function automatic logic [15:0] crc_of(input logic [7:0] b [0:11], input int n);
        logic [15:0] c;
        c = 16'hFFFF;
        for (int j = 0; j < n; j++) begin
            c = c ^ {b[j], 8'h00};
            for (int k = 0; k < 8; k++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        end
        return c;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clr();
        rn = 0;
        for (int j = 0; j < 4; j++) pc[j] = 0;
    endtask

    task automatic put(input logic [7:0] b);
        in_valid = 1'b1;
        in_data  = b;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // gap_before: byte index before which gap_len idle cycles are inserted (-1 none)
    task automatic send_frame(input logic [7:0] code, input logic [15:0] s [0:3],
                              input bit bad_crc, input int gap_before, input int gap_len);
        logic [7:0]  b [0:11];
        logic [15:0] c;
        b[0] = 8'hFF;
        b[1] = code;
        for (int j = 0; j < 4; j++) begin
            b[2+2*j] = s[j][7:0];
            b[3+2*j] = s[j][15:8];
        end
        c = crc_of(b, 10);
        if (bad_crc) c = c ^ 16'h0100;
        b[10] = c[7:0];
        b[11] = c[15:8];
        for (int j = 0; j < 12; j++) begin
            if (j == gap_before) idle(gap_len);
            put(b[j]);
        end
    endtask

    // kind: 0 none, 3 ack, 4 error; pulse_idx -1 for none
    task automatic expect_result(input string req, input int kind, input int pulse_idx);
        logic [7:0]  rb [0:11];
        logic [15:0] c;
        idle(12);
        chk({req, " reply length"}, rn, (kind == 0) ? 0 : 4);
        if (kind != 0 && rn == 4) begin
            rb[0] = 8'hFF;
            rb[1] = 8'(kind);
            c = crc_of(rb, 2);
            chk({req, " reply header"}, rbuf[0], 8'hFF);
            chk({req, " reply id"}, rbuf[1], kind);
            chk({req, " reply crc"}, {rbuf[3], rbuf[2]}, c);
        end
        for (int j = 0; j < 4; j++)
            chk({req, " R3 pulse count"}, pc[j], (j == pulse_idx) ? 1 : 0);
        for (int j = 0; j < 4; j++) begin
            chk({req, " R4 setpoint"}, setpt_o[16*j +: 16], exp_sp[j]);
            chk({req, " R5 auto flag"}, auto_isc_o[j], exp_sp[j] == 16'h8000);
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] s [0:3];
        for (int j = 0; j < 4; j++) begin
            pc[j] = 0;
            exp_sp[j] = 16'h0000;
        end
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R12 reset state
        chk("R12 out_valid", out_valid, 0);
        chk("R12 in_ready", in_ready, 1);
        chk("R12 setpoints", setpt_o, 64'h0);
        chk("R12 auto", auto_isc_o, 0);
        chk("R12 pulses", {act_get_status, act_get_curves, act_send_status, act_send_all}, 0);

        // R1 junk before header is dropped, R6 ack for code 1
        clr();
        put(8'h12); put(8'h00); put(8'h03);
        s[0] = 16'h1234; s[1] = 16'h00FF; s[2] = 16'hFF00; s[3] = 16'hFFFF;
        send_frame(8'd1, s, 1'b0, -1, 0);
        for (int j = 0; j < 4; j++) exp_sp[j] = s[j];
        expect_result("R1 R6 junk then code1", 3, 0);

        // Sweep of codes 0..7 (R3 R4 R5 R6 R7 R8)
        for (int code = 0; code < 8; code++) begin
            clr();
            for (int j = 0; j < 4; j++)
                s[j] = 16'(code * 16'h1111 + j * 16'h0203 + 1);
            s[code % 4]       = 16'h8000;
            s[(code + 1) % 4] = 16'hFFFF;
            send_frame(8'(code), s, 1'b0, -1, 0);
            if (code >= 1 && code <= 4) begin
                for (int j = 0; j < 4; j++) exp_sp[j] = s[j];
                expect_result((code <= 2) ? "R6 sweep ack" : "R8 sweep silent",
                              (code <= 2) ? 3 : 0, code - 1);
            end else begin
                expect_result("R7 sweep unknown code", 4, -1);
            end
        end

        // R2 bad CRC on each valid code
        for (int code = 1; code <= 4; code++) begin
            clr();
            for (int j = 0; j < 4; j++) s[j] = 16'h0A0A + 16'(code);
            send_frame(8'(code), s, 1'b1, -1, 0);
            expect_result("R2 bad crc", 4, -1);
        end

        // R9 gap one below the limit keeps the frame
        clr();
        for (int j = 0; j < 4; j++) s[j] = 16'h3000 + 16'(j);
        send_frame(8'd2, s, 1'b0, 5, GAP - 1);
        for (int j = 0; j < 4; j++) exp_sp[j] = s[j];
        expect_result("R9 gap below limit", 3, 1);

        // R9 gap at the limit abandons the frame
        clr();
        for (int j = 0; j < 4; j++) s[j] = 16'h4100 + 16'(j);
        send_frame(8'd2, s, 1'b0, 5, GAP);
        expect_result("R9 gap at limit", 0, -1);

        // R10 window drop mid-frame abandons it
        clr();
        put(8'hFF); put(8'h01); put(8'h11);
        window_en = 1'b0; idle(1); window_en = 1'b1;
        put(8'h22); put(8'h33); put(8'h44); put(8'h55);
        put(8'h66); put(8'h77); put(8'h12); put(8'h34);
        expect_result("R10 window drop", 0, -1);

        // R10 whole frame while window closed
        clr();
        window_en = 1'b0;
        for (int j = 0; j < 4; j++) s[j] = 16'h5500;
        send_frame(8'd3, s, 1'b0, -1, 0);
        window_en = 1'b1;
        expect_result("R10 window closed", 0, -1);

        // R11 stalled output holds header, input blocked
        clr();
        out_ready = 1'b0;
        for (int j = 0; j < 4; j++) s[j] = 16'h0100 * 16'(j + 1);
        send_frame(8'd1, s, 1'b0, -1, 0);
        for (int j = 0; j < 4; j++) exp_sp[j] = s[j];
        idle(6);
        @(negedge clk);
        chk("R11 valid during stall", out_valid, 1);
        chk("R11 data held during stall", out_data, 8'hFF);
        chk("R11 in_ready low during reply", in_ready, 0);
        @(posedge clk); #1;
        out_ready = 1'b1;
        expect_result("R11 after stall", 3, 0);
        chk("R11 in_ready back", in_ready, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule